// File: doc/BRIEF.md
# Digital Component Video Line Formatter

This block turns a stream of component video samples into a byte-serial 8-bit 4:2:2 video signal, one byte per pixel clock. Each line starts with an end-of-active-video reference code, then a horizontal blanking interval filled with the alternating black-level filler, then a start-of-active-video reference code, then the active region of 1440 bytes (720 pixels) multiplexed as Cb, Y, Cr, Y. Reference codes carry the field and vertical-blanking state of the line and a set of protection bits, so a receiver can lock to the stream without separate sync wires.

The block never stalls: the byte position advances on every clock. Samples arrive on a valid/ready interface. `s_ready` is high exactly on the clocks whose output byte lies in the active region, and one sample beat is consumed on every such clock where `s_valid` is also high. The source cannot apply back-pressure to the output. If the source has no beat ready, the byte slot is filled with black-level filler and the line timing is kept. Outside the active region, `s_valid` is ignored. The line-level controls (field, blanking, V-bit source, code suppression, composite substitution) are plain inputs that are sampled once per line, at fixed positions.

Top module: `vfmt_top`

## Requirements
- R1: While `rst_n` is low, `vid_o` is 0x10 and `s_ready` is 0. The first clock edge after reset is released emits byte position 0 of a line, which is the first end-code byte 0xFF.
- R2: Line positions 0..3 carry the end code 0xFF, 0x00, 0x00, XY. XY has H=1.
- R3: The XY byte has bit 7 = 1, bit 6 = F, bit 5 = V and bit 4 = H. Bits 3..0 are the protection bits P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H.
- R4: Between the end code and the start code, every byte is 0x80 at even line positions and 0x10 at odd line positions. After position LINE_BYTES-1 the next position is 0.
- R5: Positions LINE_BYTES-1444..LINE_BYTES-1441 carry the start code 0xFF, 0x00, 0x00, XY. XY has H=0 and the same F and V as the end code of the same line.
- R6: The last 1440 positions form the active region. Byte k of this region carries Cb when k mod 4 = 0, Y when k mod 4 is 1 or 3, and Cr when k mod 4 = 2. `s_ready` is high on exactly these positions.
- R7: F and V are taken from the inputs only on the clock that emits position 0. Input changes at any other point in the line have no effect on that line's codes.
- R8: With `vsel_i` = 0, V follows `vblank_i`. With `vsel_i` = 1, V follows `vwin_i`.
- R9: When `suppress_i` is 1 at position 0, both codes of that line are replaced by the filler pattern of R4, so no 0xFF or 0x00 appears in the line.
- R10: When `raw_i` is 1 on the clock that emits the first start-code byte, every Y position of that line's active region carries `s_cvbs`. Cb and Cr positions are unchanged. `raw_i` has no effect at any other clock.
- R11: Active-region sample bytes are clamped: 0x00 is sent as 0x01 and 0xFF is sent as 0xFE.
- R12: An active position with `s_valid` low sends 0x80 at a Cb or Cr position and 0x10 at a Y position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_i | input | 1 | Field of the coming line (0 first, 1 second) |
| vblank_i | input | 1 | Coming line is in vertical blanking |
| vwin_i | input | 1 | Alternate vertical-window indication |
| vsel_i | input | 1 | V-bit source select (0 vblank_i, 1 vwin_i) |
| raw_i | input | 1 | Substitute composite samples for luma on this line |
| suppress_i | input | 1 | Replace this line's reference codes with filler |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Formatter takes a beat on this clock |
| s_cb | input | 8 | Blue-difference sample |
| s_y | input | 8 | Luma sample |
| s_cr | input | 8 | Red-difference sample |
| s_cvbs | input | 8 | Composite sample |
| vid_o | output | 8 | Formatted byte stream |

## Verification
Every output byte comes out of a single register. The byte for line position p therefore appears on the first clock edge taken with the internal position at p. `s_ready` is combinational and is valid during the clock before that edge. The bench tracks its own position counter from reset release. It drives controls and sample beats at the falling edge before the rising edge that consumes them. It checks `s_ready` at that same falling edge and checks `vid_o` at the next falling edge. Line controls are flipped in mid-line, after their sampling point, and the bench expects the codes and samples of that line to stay unchanged.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

  typedef enum logic [1:0] {
    RG_EAV   = 2'd0,
    RG_BLANK = 2'd1,
    RG_SAV   = 2'd2,
    RG_ACT   = 2'd3
  } region_t;

  localparam logic [7:0] FILL_EVEN = 8'h80;
  localparam logic [7:0] FILL_ODD  = 8'h10;

  function automatic logic [7:0] xy_code(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] clamp_smp(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;
    if (s == 8'hFF) return 8'hFE;
    return s;
  endfunction

endpackage

// File: rtl/vfmt_line_timer.sv
module vfmt_line_timer
  import vfmt_pkg::*;
#(
  parameter int LINE_BYTES = 1716,
  parameter int ACT_BYTES  = 1440
) (
  input  logic       clk,
  input  logic       rst_n,
  output region_t    region,
  output logic [1:0] code_idx,
  output logic [1:0] act_phase,
  output logic       par,
  output logic       line_start,
  output logic       sav_start
);
  localparam int CW = $clog2(LINE_BYTES);
  localparam logic [CW-1:0] LAST   = CW'(LINE_BYTES - 1);
  localparam logic [CW-1:0] SAV_AT = CW'(LINE_BYTES - ACT_BYTES - 4);
  localparam logic [CW-1:0] ACT_AT = CW'(LINE_BYTES - ACT_BYTES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cnt < CW'(4))     region = RG_EAV;
    else if (cnt < SAV_AT) region = RG_BLANK;
    else if (cnt < ACT_AT) region = RG_SAV;
    else                   region = RG_ACT;
  end

  assign code_idx   = (region == RG_SAV) ? (cnt[1:0] - SAV_AT[1:0]) : cnt[1:0];
  assign act_phase  = cnt[1:0] - ACT_AT[1:0];
  assign par        = cnt[0];
  assign line_start = (cnt == '0);
  assign sav_start  = (cnt == SAV_AT);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> (cnt == '0));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/vfmt_ctl_latch.sv
module vfmt_ctl_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic sav_start,
  input  logic field_i,
  input  logic vblank_i,
  input  logic vwin_i,
  input  logic vsel_i,
  input  logic raw_i,
  input  logic suppress_i,
  output logic eff_f,
  output logic eff_v,
  output logic eff_supp,
  output logic raw_q
);
  logic f_q, v_q, supp_q;
  logic v_src;

  assign v_src = vsel_i ? vwin_i : vblank_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= 1'b0;
      v_q    <= 1'b0;
      supp_q <= 1'b0;
    end else if (line_start) begin
      f_q    <= field_i;
      v_q    <= v_src;
      supp_q <= suppress_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         raw_q <= 1'b0;
    else if (sav_start) raw_q <= raw_i;
  end

  assign eff_f    = line_start ? field_i    : f_q;
  assign eff_v    = line_start ? v_src      : v_q;
  assign eff_supp = line_start ? suppress_i : supp_q;

  a_r7_fv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(f_q) && $stable(v_q) && $stable(supp_q)));
  a_r10_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sav_start |=> $stable(raw_q));

endmodule

// File: rtl/vfmt_byte_mux.sv
module vfmt_byte_mux
  import vfmt_pkg::*;
(
  input  region_t    region,
  input  logic [1:0] code_idx,
  input  logic [1:0] act_phase,
  input  logic       par,
  input  logic       f,
  input  logic       v,
  input  logic       supp,
  input  logic       raw,
  input  logic       valid,
  input  logic [7:0] cb,
  input  logic [7:0] y,
  input  logic [7:0] cr,
  input  logic [7:0] cvbs,
  output logic [7:0] byte_o
);
  logic [7:0] filler;
  logic [7:0] code_byte;
  logic [7:0] act_byte;
  logic       luma_pos;

  assign filler   = par ? FILL_ODD : FILL_EVEN;
  assign luma_pos = act_phase[0];

  always_comb begin
    unique case (code_idx)
      2'd0:    code_byte = 8'hFF;
      2'd3:    code_byte = xy_code(f, v, region == RG_EAV);
      default: code_byte = 8'h00;
    endcase
  end

  always_comb begin
    if (!valid)        act_byte = luma_pos ? FILL_ODD : FILL_EVEN;
    else if (luma_pos) act_byte = clamp_smp(raw ? cvbs : y);
    else               act_byte = clamp_smp(act_phase[1] ? cr : cb);
  end

  always_comb begin
    unique case (region)
      RG_EAV, RG_SAV: byte_o = supp ? filler : code_byte;
      RG_BLANK:       byte_o = filler;
      default:        byte_o = act_byte;
    endcase
  end

endmodule

// File: rtl/vfmt_top.sv
module vfmt_top
  import vfmt_pkg::*;
#(
  parameter int LINE_BYTES = 1716,
  parameter int ACT_PIX    = 720
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_i,
  input  logic       vblank_i,
  input  logic       vwin_i,
  input  logic       vsel_i,
  input  logic       raw_i,
  input  logic       suppress_i,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_cb,
  input  logic [7:0] s_y,
  input  logic [7:0] s_cr,
  input  logic [7:0] s_cvbs,
  output logic [7:0] vid_o
);
  localparam int ACT_BYTES = 2 * ACT_PIX;

  region_t    region, prev_region;
  logic [1:0] code_idx, act_phase;
  logic       par, line_start, sav_start;
  logic       eff_f, eff_v, eff_supp, raw_q;
  logic [7:0] nxt_byte;

  vfmt_line_timer #(.LINE_BYTES(LINE_BYTES), .ACT_BYTES(ACT_BYTES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .region(region), .code_idx(code_idx),
    .act_phase(act_phase), .par(par), .line_start(line_start), .sav_start(sav_start)
  );

  vfmt_ctl_latch u_ctl (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .sav_start(sav_start),
    .field_i(field_i), .vblank_i(vblank_i), .vwin_i(vwin_i), .vsel_i(vsel_i),
    .raw_i(raw_i), .suppress_i(suppress_i),
    .eff_f(eff_f), .eff_v(eff_v), .eff_supp(eff_supp), .raw_q(raw_q)
  );

  vfmt_byte_mux u_mux (
    .region(region), .code_idx(code_idx), .act_phase(act_phase), .par(par),
    .f(eff_f), .v(eff_v), .supp(eff_supp), .raw(raw_q), .valid(s_valid),
    .cb(s_cb), .y(s_y), .cr(s_cr), .cvbs(s_cvbs), .byte_o(nxt_byte)
  );

  assign s_ready = (region == RG_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_o       <= FILL_ODD;
      prev_region <= RG_EAV;
    end else begin
      vid_o       <= nxt_byte;
      prev_region <= region;
    end
  end

  a_r11_no_sync_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_region == RG_ACT) |-> (vid_o != 8'h00 && vid_o != 8'hFF));
  a_r4_blank_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_region == RG_BLANK) |-> (vid_o == FILL_EVEN || vid_o == FILL_ODD));
  a_r5_sav_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_region == RG_BLANK && region == RG_SAV) |=> (region == RG_SAV));

endmodule

// File: tb/sim_vfmt_top.sv
`timescale 1ns/1ps
module sim_vfmt_top;
  localparam int LINE   = 1716;
  localparam int ACT_AT = LINE - 1440;
  localparam int SAV_AT = ACT_AT - 4;
  localparam int NLINES = 5;

  // cfg[22:16] = {field, vblank, vwin, vsel, raw, suppress, starve}
  // [15:8] expected end-code XY, [7:0] expected start-code XY
  localparam logic [22:0] TBL [NLINES] = '{
    {7'b0100000, 8'hB6, 8'hAB},
    {7'b1011000, 8'hF1, 8'hEC},
    {7'b0000101, 8'h9D, 8'h80},
    {7'b1101010, 8'h00, 8'h00},
    {7'b0001100, 8'h9D, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_i = 0, vblank_i = 0, vwin_i = 0, vsel_i = 0, raw_i = 0, suppress_i = 0;
  logic s_valid = 0;
  logic s_ready;
  logic [7:0] s_cb = 0, s_y = 0, s_cr = 0, s_cvbs = 0;
  logic [7:0] vid_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vfmt_top u0 (
    .clk(clk), .rst_n(rst_n), .field_i(field_i), .vblank_i(vblank_i), .vwin_i(vwin_i),
    .vsel_i(vsel_i), .raw_i(raw_i), .suppress_i(suppress_i), .s_valid(s_valid),
    .s_ready(s_ready), .s_cb(s_cb), .s_y(s_y), .s_cr(s_cr), .s_cvbs(s_cvbs), .vid_o(vid_o)
  );

  function automatic logic [7:0] clampb(input logic [7:0] s);
    if (s == 8'h00) return 8'h01;
    if (s == 8'hFF) return 8'hFE;
    return s;
  endfunction

  task automatic chk(input string tag, input int pos, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos %0d actual %02h expected %02h", tag, pos, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [6:0] c);
    field_i = c[6]; vblank_i = c[5]; vwin_i = c[4]; vsel_i = c[3];
    raw_i = c[2]; suppress_i = c[1];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset vid", -1, vid_o, 8'h10);
    chk("R1 reset ready", -1, {7'd0, s_ready}, 8'h00);
    rst_n = 1'b1;

    for (int l = 0; l < NLINES; l++) begin
      logic [6:0] cfg;
      cfg = TBL[l][22:16];
      for (int p = 0; p < LINE; p++) begin
        logic [7:0] exp;
        string tag;
        int idx;
        if (p == 0) set_ctl(cfg);
        if (p == 500) set_ctl(~cfg);          // R7/R9/R10: late changes ignored
        idx = p - ACT_AT;
        if (p >= ACT_AT) begin
          s_valid = !(cfg[0] && (idx % 7 == 3));
          s_cb = 8'(idx * 3); s_y = 8'(idx * 7 + 1);
          s_cr = ~8'(idx * 3); s_cvbs = 8'(idx * 11 + 2);
        end else begin
          s_valid = 1'b1; s_cb = 8'h00; s_y = 8'hFF; s_cr = 8'h00; s_cvbs = 8'hFF;
        end
        chk("R6 ready", p, {7'd0, s_ready}, {7'd0, (p >= ACT_AT)});
        @(posedge clk);
        @(negedge clk);
        if (p < 4 || (p >= SAV_AT && p < ACT_AT)) begin
          int k;
          k = (p < 4) ? p : p - SAV_AT;
          if (cfg[1]) begin exp = (p % 2 == 0) ? 8'h80 : 8'h10; tag = "R9 suppressed code"; end
          else if (k == 0) begin exp = 8'hFF; tag = (p < 4) ? "R2 eav" : "R5 sav"; end
          else if (k == 3) begin
            exp = (p < 4) ? TBL[l][15:8] : TBL[l][7:0];
            tag = (p < 4) ? "R3 R8 eav xy" : "R3 R5 sav xy";
          end else begin exp = 8'h00; tag = (p < 4) ? "R2 eav" : "R5 sav"; end
        end else if (p < SAV_AT) begin
          exp = (p % 2 == 0) ? 8'h80 : 8'h10; tag = "R4 filler";
        end else begin
          int ph;
          ph = idx % 4;
          if (cfg[0] && (idx % 7 == 3)) begin
            exp = (ph % 2 == 1) ? 8'h10 : 8'h80; tag = "R12 starved";
          end else if (ph == 0) begin exp = clampb(8'(idx * 3)); tag = "R6 R11 cb"; end
          else if (ph == 2) begin exp = clampb(~8'(idx * 3)); tag = "R6 R11 cr"; end
          else if (cfg[2]) begin exp = clampb(8'(idx * 11 + 2)); tag = "R10 cvbs"; end
          else begin exp = clampb(8'(idx * 7 + 1)); tag = "R6 R11 y"; end
        end
        chk(tag, p, vid_o, exp);
      end
    end

    // R1: reset in mid-stream, then restart at line position 0
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid reset vid", -1, vid_o, 8'h10);
    chk("R1 mid reset ready", -1, {7'd0, s_ready}, 8'h00);
    set_ctl(7'b1100000);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] exp;
      exp = (p == 0) ? 8'hFF : (p == 3) ? 8'hF1 : 8'h00;
      @(posedge clk);
      @(negedge clk);
      chk("R1 R2 restart", p, vid_o, exp);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule